// File: doc/BRIEF.md
# Branch History Table Predictor

This block predicts the direction and destination of branches for an instruction fetch unit. It is a direct-mapped table of 16 entries. Each entry stores the upper part of a branch instruction address as a tag, a two-bit history state and the branch target address. The fetch unit presents its fetch address every cycle. When the entry selected by the low address bits is valid and its tag matches, the block reports a hit with a taken or not-taken guess and the stored target.

When a branch resolves, the execute stage drives the update port with the branch address, its real direction and its real target. A hit on the update address moves the entry's history state. A miss claims the entry and seeds its history from the outcome. The history scheme reverses its guess only after two consecutive wrong outcomes. As a result, a single loop exit does not spoil the prediction for the next time the loop runs.

Lookup is combinational from the stored contents and updates take effect at the clock edge. A lookup and an update in the same cycle therefore always see the contents from before the update.

Top module: `bht_predictor`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, so every lookup misses.
- R2: On a lookup miss, `lk_hit` is 0, `lk_taken` is 0 and `lk_target` is all zeros.
- R3: An update whose address misses allocates the entry at index `addr[3:0]` with tag `addr[15:4]`. Its history becomes 2'b10 when the branch was taken and 2'b11 when it was not.
- R4: A lookup hit returns the last target written to that entry. It predicts taken for history states 2'b10 and 2'b01 and not taken for 2'b11 and 2'b00.
- R5: An update that hits moves the history as follows: 10 goes to 01 on not taken; 01 goes to 10 on taken and to 11 on not taken; 11 goes to 00 on taken; 00 goes to 10 on taken and to 11 on not taken. Every other combination keeps the state. The update also writes the new target.
- R6: From a state reached by two agreeing outcomes (10 or 11), one disagreeing outcome does not change the prediction.
- R7: An address that shares an index with a stored entry but has a different tag misses. Updating with that address replaces the entry, and the old address then misses.
- R8: When a lookup and an update select the same entry in the same cycle, the lookup returns the state and target from before the update.
- R9: While `up_valid` is 0, the update inputs change nothing in the table.
- R10: A loop branch that was taken several times and then not taken once is still predicted taken on its next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_addr | input | 16 | Fetch address to look up |
| lk_hit | output | 1 | Selected entry is valid and its tag matches |
| lk_taken | output | 1 | Predicted taken (0 on a miss) |
| lk_target | output | 16 | Stored branch target (0 on a miss) |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_addr | input | 16 | Address of the resolved branch |
| up_taken | input | 1 | Real direction of the resolved branch |
| up_target | input | 16 | Real target of the resolved branch |

## Verification
Directed outcome sequences walk one entry through every history state and every transition. They separate a correct two-disagreement rule from a one-bit or saturating-counter scheme, because those schemes give different guesses after the alternating T/NT patterns. Aliasing addresses that share an index but differ in tag check that a tag compare, and not the index alone, decides a hit. A same-cycle lookup and update on one entry shows whether the lookup sees old or new contents. A long run of random outcomes over a small address pool, with frequent collisions, is compared against a bench model of the table. That run exercises allocation, replacement and idle update inputs in mixed order.

// File: rtl/bht_pkg.sv
// Package: shared types and helpers for the branch history table.
// Assumes two-bit history states whose codes are fixed by the requirements.
package bht_pkg;

    typedef enum logic [1:0] {
        H_NT_T = 2'b00,   // not taken, then taken
        H_T_NT = 2'b01,   // taken, then not taken
        H_TT   = 2'b10,   // taken twice
        H_NTNT = 2'b11    // not taken twice
    } hist_e;

    // Direction guessed from a history state.
    function automatic logic hist_predicts(hist_e h);
        return (h == H_TT) || (h == H_T_NT);
    endfunction

endpackage

// File: rtl/bht_hist_fsm.sv
// Module: bht_hist_fsm
// Computes the history state to write on an update. On a hit it applies the
// two-disagreement transition rule. On a miss it seeds a fresh entry from the
// outcome. Purely combinational; assumes cur_i is only meaningful when hit_i is 1.
module bht_hist_fsm
    import bht_pkg::*;
(
    input  logic  hit_i,
    input  hist_e cur_i,
    input  logic  taken_i,
    output hist_e nxt_o
);

    // Select the next state from the current one and the resolved outcome.
    always_comb begin
        nxt_o = cur_i;
        if (!hit_i) begin
            nxt_o = taken_i ? H_TT : H_NTNT;
        end else begin
            unique case (cur_i)
                H_TT:    if (!taken_i) nxt_o = H_T_NT;
                H_T_NT:  nxt_o = taken_i ? H_TT : H_NTNT;
                H_NTNT:  if (taken_i)  nxt_o = H_NT_T;
                H_NT_T:  nxt_o = taken_i ? H_TT : H_NTNT;
                default: nxt_o = cur_i;
            endcase
        end
    end

endmodule

// File: rtl/bht_table.sv
// Module: bht_table
// Direct-mapped storage: one valid bit, tag, history state and target per entry.
// Two combinational read ports (lookup and update side) and one write port.
// A write takes effect at the clock edge, so reads in the same cycle see old data.
// Only the valid bits are reset; the other fields are written before any use.
module bht_table
    import bht_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 12,
    parameter int TGT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    // lookup read port
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    output hist_e            a_hist,
    output logic [TGT_W-1:0] a_tgt,
    // update-side read port
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    output hist_e            b_hist,
    // write port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  hist_e            wr_hist,
    input  logic [TGT_W-1:0] wr_tgt
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    hist_e            hist_q [DEPTH];
    logic [TGT_W-1:0] tgt_q  [DEPTH];

    // Valid bits: cleared by reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Entry fields: written whole on every accepted write, outside reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            hist_q[wr_idx] <= wr_hist;
            tgt_q[wr_idx]  <= wr_tgt;
        end
    end

    // Lookup port: tag compare and field read.
    assign a_hit  = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
    assign a_hist = hist_q[a_idx];
    assign a_tgt  = tgt_q[a_idx];

    // Update port: tag compare and current history.
    assign b_hit  = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
    assign b_hist = hist_q[b_idx];

endmodule

// File: rtl/bht_predictor.sv
// Module: bht_predictor (top)
// Branch history table predictor. Lookup splits the fetch address into index
// and tag and returns hit, direction and target combinationally. An update
// either advances the history of a matching entry or allocates the entry.
// Assumes at most one update per cycle; a same-cycle lookup sees pre-update data.
module bht_predictor
    import bht_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int TGT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [TGT_W-1:0]  lk_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_taken,
    input  logic [TGT_W-1:0]  up_target
);

    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             lk_hit_raw;
    hist_e            lk_hist;
    logic [TGT_W-1:0] lk_tgt_raw;
    logic             up_hit;
    hist_e            up_hist;
    hist_e            up_hist_nxt;

    // Address split: low bits index, high bits tag.
    assign lk_idx = lk_addr[IDX_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
    assign up_idx = up_addr[IDX_W-1:0];
    assign up_tag = up_addr[ADDR_W-1:IDX_W];

    bht_table #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .TGT_W (TGT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (lk_idx),
        .a_tag   (lk_tag),
        .a_hit   (lk_hit_raw),
        .a_hist  (lk_hist),
        .a_tgt   (lk_tgt_raw),
        .b_idx   (up_idx),
        .b_tag   (up_tag),
        .b_hit   (up_hit),
        .b_hist  (up_hist),
        .wr_en   (up_valid),
        .wr_idx  (up_idx),
        .wr_tag  (up_tag),
        .wr_hist (up_hist_nxt),
        .wr_tgt  (up_target)
    );

    bht_hist_fsm u_fsm (
        .hit_i   (up_hit),
        .cur_i   (up_hist),
        .taken_i (up_taken),
        .nxt_o   (up_hist_nxt)
    );

    // Lookup outputs: direction and target forced low on a miss.
    assign lk_hit    = lk_hit_raw;
    assign lk_taken  = lk_hit_raw && hist_predicts(lk_hist);
    assign lk_target = lk_hit_raw ? lk_tgt_raw : '0;

endmodule

// File: rtl/bht_predictor_chk.sv
// Module: bht_predictor_chk
// Assertion checker bound to bht_predictor. It observes the ports plus the
// update-side hit and history that the table drives inside the top.
module bht_predictor_chk
    import bht_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TGT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic              lk_taken,
    input logic [TGT_W-1:0]  lk_target,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_taken,
    input logic [TGT_W-1:0]  up_target,
    input logic              up_hit,
    input hist_e             up_hist
);

    // R1: the first cycle after reset finds an empty table.
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit);

    // R2: a miss never reports taken or a target.
    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_target == '0));

    // R3: a fresh entry predicts the outcome that allocated it.
    p_alloc_pred_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid && !up_hit) && lk_addr == $past(up_addr))
            |-> (lk_hit && lk_taken == $past(up_taken)));

    // R4: an updated entry hits and returns the written target.
    p_target_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid) && lk_addr == $past(up_addr))
            |-> (lk_hit && lk_target == $past(up_target)));

    // R6: from a two-agree state, one update keeps the prediction.
    p_flip_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid && up_hit && (up_hist == H_TT || up_hist == H_NTNT))
            && up_addr == $past(up_addr))
            |-> (hist_predicts(up_hist) == $past(hist_predicts(up_hist))));

    // R9: without an update, a held lookup address gives unchanged outputs.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!up_valid) && $stable(lk_addr))
            |-> ($stable(lk_hit) && $stable(lk_taken) && $stable(lk_target)));

endmodule

bind bht_predictor bht_predictor_chk #(
    .ADDR_W (ADDR_W),
    .TGT_W  (TGT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_taken  (lk_taken),
    .lk_target (lk_target),
    .up_valid  (up_valid),
    .up_addr   (up_addr),
    .up_taken  (up_taken),
    .up_target (up_target),
    .up_hit    (up_hit),
    .up_hist   (up_hist)
);

// File: tb/bht_predictor_bench.sv
// Bench for bht_predictor: directed corner cases followed by seeded random
// traffic, all compared against a table model built from the requirements.
module bht_predictor_bench;

    localparam int ADDR_W = 16;
    localparam int IDX_W  = 4;
    localparam int TGT_W  = 16;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit, lk_taken;
    logic [TGT_W-1:0]  lk_target;
    logic              up_valid = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic              up_taken = 1'b0;
    logic [TGT_W-1:0]  up_target = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model of the table
    bit                      m_valid [DEPTH];
    logic [ADDR_W-IDX_W-1:0] m_tag   [DEPTH];
    logic [1:0]              m_hist  [DEPTH];
    logic [TGT_W-1:0]        m_tgt   [DEPTH];

    always #5 clk = ~clk;

    bht_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TGT_W(TGT_W)) u_bht_predictor (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .lk_target(lk_target), .up_valid(up_valid),
        .up_addr(up_addr), .up_taken(up_taken), .up_target(up_target)
    );

    // Prediction per R4: 10 and 01 taken, 11 and 00 not taken.
    function automatic bit exp_pred(logic [1:0] h);
        return (h == 2'b10) || (h == 2'b01);
    endfunction

    // Transition table per R5.
    function automatic logic [1:0] exp_next(logic [1:0] h, bit t);
        case (h)
            2'b10:   return t ? 2'b10 : 2'b01;
            2'b01:   return t ? 2'b10 : 2'b11;
            2'b11:   return t ? 2'b00 : 2'b11;
            default: return t ? 2'b10 : 2'b11;
        endcase
    endfunction

    function automatic bit m_hit(logic [ADDR_W-1:0] a);
        return m_valid[a[IDX_W-1:0]] && (m_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W]);
    endfunction

    task automatic check_lookup(string req);
        bit               eh;
        bit               et;
        logic [TGT_W-1:0] eg;
        eh = m_hit(lk_addr);
        et = eh && exp_pred(m_hist[lk_addr[IDX_W-1:0]]);
        eg = eh ? m_tgt[lk_addr[IDX_W-1:0]] : '0;
        n_checks++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
            n_fail++;
            $display("FAIL %s addr=%h: hit/taken/target actual %b/%b/%h expected %b/%b/%h",
                     req, lk_addr, lk_hit, lk_taken, lk_target, eh, et, eg);
        end
    endtask

    // One cycle: drive at the falling edge, check the lookup, then commit the model.
    task automatic step(logic [ADDR_W-1:0] la, bit uv, logic [ADDR_W-1:0] ua,
                        bit ut, logic [TGT_W-1:0] ug, string req);
        int i;
        @(negedge clk);
        lk_addr = la; up_valid = uv; up_addr = ua; up_taken = ut; up_target = ug;
        #1;
        check_lookup(req);
        @(posedge clk);
        if (uv) begin
            i = int'(ua[IDX_W-1:0]);
            if (m_hit(ua)) begin
                m_hist[i] = exp_next(m_hist[i], ut);
            end else begin
                m_valid[i] = 1'b1;
                m_tag[i]   = ua[ADDR_W-1:IDX_W];
                m_hist[i]  = ut ? 2'b10 : 2'b11;
            end
            m_tgt[i] = ug;
        end
    endtask

    task automatic upd(logic [ADDR_W-1:0] a, bit t, logic [TGT_W-1:0] g, string req);
        step(a, 1'b1, a, t, g, req);
    endtask

    task automatic look(logic [ADDR_W-1:0] a, string req);
        step(a, 1'b0, '0, 1'b0, '0, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_hist[i] = 2'b11; m_tgt[i] = '0;
        end
        void'($urandom(32'd4717));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: empty table after reset
        look(16'h0000, "R1");
        look(16'h1235, "R1");
        look(16'hFFFF, "R2");

        // R3: allocation seeds from outcome
        upd(16'h0103, 1'b1, 16'hA000, "R3");
        look(16'h0103, "R3");
        upd(16'h0205, 1'b0, 16'hB000, "R3");
        look(16'h0205, "R3");

        // R5 / R6: walk entry 0x0103 (state 10) through every state
        upd(16'h0103, 1'b1, 16'hA001, "R5");   // 10 -> 10
        look(16'h0103, "R5");
        upd(16'h0103, 1'b0, 16'hA002, "R6");   // 10 -> 01, still taken
        look(16'h0103, "R6");
        upd(16'h0103, 1'b1, 16'hA003, "R5");   // 01 -> 10
        look(16'h0103, "R5");
        upd(16'h0103, 1'b0, 16'hA004, "R5");   // 10 -> 01
        upd(16'h0103, 1'b0, 16'hA005, "R5");   // 01 -> 11, not taken
        look(16'h0103, "R5");
        upd(16'h0103, 1'b0, 16'hA006, "R5");   // 11 -> 11
        look(16'h0103, "R5");
        upd(16'h0103, 1'b1, 16'hA007, "R6");   // 11 -> 00, still not taken
        look(16'h0103, "R6");
        upd(16'h0103, 1'b0, 16'hA008, "R5");   // 00 -> 11
        look(16'h0103, "R5");
        upd(16'h0103, 1'b1, 16'hA009, "R5");   // 11 -> 00
        upd(16'h0103, 1'b1, 16'hA00A, "R4");   // 00 -> 10, taken with new target
        look(16'h0103, "R4");

        // R8: same-cycle lookup and update on one entry sees old contents
        step(16'h0103, 1'b1, 16'h0103, 1'b0, 16'hC0DE, "R8");
        look(16'h0103, "R8");

        // R9: idle update inputs change nothing
        step(16'h0205, 1'b0, 16'h0205, 1'b1, 16'hDEAD, "R9");
        look(16'h0205, "R9");
        step(16'h0405, 1'b0, 16'h0405, 1'b1, 16'hBEEF, "R9");
        look(16'h0405, "R9");

        // R7: alias on index 5 misses, then replaces
        look(16'h0305, "R7");
        upd(16'h0305, 1'b1, 16'hE000, "R7");
        look(16'h0305, "R7");
        look(16'h0205, "R7");

        // R10: loop branch taken five times, exits once, re-entered
        for (int k = 0; k < 5; k++) upd(16'h0A0C, 1'b1, 16'h0A00, "R10");
        upd(16'h0A0C, 1'b0, 16'h0A00, "R10");
        look(16'h0A0C, "R10");

        // Random traffic over a small colliding address pool (R4, R5, R7, R9)
        for (int n = 0; n < 4000; n++) begin
            logic [ADDR_W-1:0] la, ua;
            la = {10'd0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
            ua = ($urandom_range(0, 3) == 0) ? la
                 : {10'd0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
            step(la, ($urandom_range(0, 2) != 0), ua, 1'($urandom),
                 16'($urandom), "R5");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule